// File: doc/BRIEF.md
# Mainboard Bus Decoder with Acknowledge Timeout

This block sits on the mainboard of a 32-bit asynchronous-handshake processor bus. On every bus cycle it compares the address with two fixed on-board windows. One window holds the boot ROM and the other a byte-wide serial controller. For a hit it drives that device's chip select. After a fixed number of wait states it returns the local size-coded cycle acknowledge on the shared, active-low, wired-OR acknowledge pair.

Only the upper half of the address map holds on-board devices. The whole lower half belongs to an external main-memory card. Upper-half addresses outside the two windows belong to peripheral cards. The block never claims those addresses and never faults them at decode time.

A watchdog counts clock edges from the assertion of the address strobe. If no agent pulls either acknowledge line low within the limit, the watchdog raises bus error. Bus error then stays raised until the strobe is released.

Top module: `mbus_ctrl`

## Requirements
- R1: A read with `as_n` low and `addr[31:19]` equal to 0x1000 (0x8000_0000 to 0x8007_FFFF) drives `rom_cs_n` low in the same cycle. A write to that window drives no select and gets no local acknowledge.
- R2: A read or write with `as_n` low and `addr[31:19]` equal to 0x1001 (0x8008_0000 to 0x800F_FFFF) drives `uart_cs_n` low in the same cycle.
- R3: When `addr[31]` is 0, no select goes low and `dsack_n_out` stays 2'b11.
- R4: A ROM cycle drives `dsack_n_out` to 2'b00 (both lines low, 32-bit port) from the ROM_WAIT-th rising edge after `as_n` falls, until `as_n` rises. Before that it is 2'b11.
- R5: A serial-controller cycle drives `dsack_n_out` to 2'b10 (bit 0 low, 8-bit port) from the UART_WAIT-th rising edge after `as_n` falls.
- R6: If neither `dsack_n_in` nor the local acknowledge has a low bit at any of the first TIMEOUT (64) rising edges with `as_n` low, `berr_n` goes low right after the TIMEOUT-th edge.
- R7: An upper-half address outside both windows raises no bus error before the timeout. An external acknowledge present at any of the first TIMEOUT edges prevents the bus error entirely.
- R8: Once low, `berr_n` stays low while `as_n` stays low, and returns high as soon as `as_n` goes high.
- R9: Raising `as_n` clears the timeout count, so each new cycle gets the full TIMEOUT edges.
- R10: After reset, and whenever `as_n` is high, both selects and `berr_n` are high and `dsack_n_out` is 2'b11. The two selects are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 32 | Cycle address |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| dsack_n_in | input | 2 | Observed wired-OR acknowledge lines, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| uart_cs_n | output | 1 | Serial controller select, active low |
| dsack_n_out | output | 2 | Local acknowledge drive, active low, 2'b11 = not driving |
| berr_n | output | 1 | Bus error, active low |

## Verification
The hardest situation to reach from the ports is an acknowledge that arrives at the very edge where the watchdog would fire. One edge early must prevent the error, and the same edge must not. The stimulus holds the strobe on an unmapped upper-half address and pulls the external lines low before sample 63, and then before sample 64. The predicted error index moves from none to 64.

A second hard case is the re-arm. A strobe is held for 40 edges without an acknowledge and then released for one cycle. The next cycle must run a full 64 edges before bus error.

A region sweep steps through the eight 512 KB pages at the bottom of the upper half, for both read and write. The expected select, acknowledge code and fault time are computed from the page index.

// File: rtl/mbus_pkg.sv
// Shared types for the mainboard bus controller.
// Assumes the two-line active-low size-coded acknowledge convention.
package mbus_pkg;

    // Which on-board device, if any, the current cycle decodes to
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_ROM  = 2'd1,
        REG_UART = 2'd2
    } region_e;

    // Acknowledge codes, bit 1 and bit 0 active low
    localparam logic [1:0] ACK_IDLE = 2'b11;
    localparam logic [1:0] ACK_LONG = 2'b00;
    localparam logic [1:0] ACK_BYTE = 2'b10;

endpackage

// File: rtl/mbus_decode.sv
// Address decoder: maps a strobed upper-half address onto an on-board
// window. Assumes each window is one page of 2**PAGE_SHIFT bytes.
// The ROM window only answers reads. The lower half is never claimed.
module mbus_decode
    import mbus_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PAGE_SHIFT = 19,
    parameter logic [31:0] ROM_BASE   = 32'h8000_0000,
    parameter logic [31:0] UART_BASE  = 32'h8008_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              rw,
    output region_e           region
);

    localparam int PW = ADDR_W - PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] ROM_B  = ROM_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] UART_B = UART_BASE[ADDR_W-1:0];
    localparam logic [PW-1:0] ROM_PAGE  = ROM_B[ADDR_W-1:PAGE_SHIFT];
    localparam logic [PW-1:0] UART_PAGE = UART_B[ADDR_W-1:PAGE_SHIFT];

    logic [PW-1:0] page;
    assign page = addr[ADDR_W-1:PAGE_SHIFT];

    // Pick the window for a strobed upper-half cycle
    always_comb begin
        region = REG_NONE;
        if (!as_n && addr[ADDR_W-1]) begin
            if (page == ROM_PAGE && rw)
                region = REG_ROM;
            else if (page == UART_PAGE)
                region = REG_UART;
        end
    end

endmodule

// File: rtl/mbus_ack_gen.sv
// Local acknowledge generator: counts edges since the strobe fell and
// drives the size-coded acknowledge once the window's wait states elapse.
// Assumes region is already gated by the strobe.
module mbus_ack_gen
    import mbus_pkg::*;
#(
    parameter int ROM_WAIT  = 1,
    parameter int UART_WAIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  region_e    region,
    output logic [1:0] dsack_n_out
);

    localparam int MAX_WAIT = (ROM_WAIT > UART_WAIT) ? ROM_WAIT : UART_WAIT;
    localparam int CW       = $clog2(MAX_WAIT + 1) + 1;
    localparam logic [CW-1:0] CMAX   = CW'(MAX_WAIT);
    localparam logic [CW-1:0] ROM_W  = CW'(ROM_WAIT);
    localparam logic [CW-1:0] UART_W = CW'(UART_WAIT);

    logic [CW-1:0] cnt;

    // Wait-state counter, saturating, cleared while the strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (as_n)
            cnt <= '0;
        else if (cnt != CMAX)
            cnt <= cnt + 1'b1;
    end

    // Size-coded acknowledge once the wait states have elapsed
    always_comb begin
        dsack_n_out = ACK_IDLE;
        if (!as_n) begin
            case (region)
                REG_ROM:  if (cnt >= ROM_W)  dsack_n_out = ACK_LONG;
                REG_UART: if (cnt >= UART_W) dsack_n_out = ACK_BYTE;
                default:  dsack_n_out = ACK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbus_timeout.sv
// Bus watchdog: counts strobed edges that carry no acknowledge and
// raises bus error on the TIMEOUT-th. The error holds until the strobe
// rises. Assumes ack_any already merges the local and external lines.
module mbus_timeout #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic ack_any,
    output logic berr_n
);

    localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT - 1);

    logic [TW-1:0] tcnt;
    logic          acked;
    logic          berr_q;

    // Count unacknowledged edges and latch the error at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt   <= '0;
            acked  <= 1'b0;
            berr_q <= 1'b0;
        end else if (as_n) begin
            tcnt   <= '0;
            acked  <= 1'b0;
            berr_q <= 1'b0;
        end else begin
            if (ack_any)
                acked <= 1'b1;
            if (!acked && !ack_any && !berr_q) begin
                if (tcnt == LIMIT)
                    berr_q <= 1'b1;
                else
                    tcnt <= tcnt + 1'b1;
            end
        end
    end

    // Drop the error as soon as the strobe rises
    assign berr_n = ~(berr_q & ~as_n);

endmodule

// File: rtl/mbus_ctrl.sv
// Mainboard bus controller top: decodes on-board windows, returns local
// acknowledges and watches every cycle for a missing acknowledge.
// Assumes dsack_n_in shows the external lines. The local drive is merged
// internally, so the block works whether or not it sees its own pull-down.
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PAGE_SHIFT = 19,
    parameter logic [31:0] ROM_BASE   = 32'h8000_0000,
    parameter logic [31:0] UART_BASE  = 32'h8008_0000,
    parameter int          ROM_WAIT   = 1,
    parameter int          UART_WAIT  = 3,
    parameter int          TIMEOUT    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              rw,
    input  logic [1:0]        dsack_n_in,
    output logic              rom_cs_n,
    output logic              uart_cs_n,
    output logic [1:0]        dsack_n_out,
    output logic              berr_n
);

    region_e region;
    logic    ack_any;

    mbus_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .ROM_BASE   (ROM_BASE),
        .UART_BASE  (UART_BASE)
    ) u_decode (
        .addr   (addr),
        .as_n   (as_n),
        .rw     (rw),
        .region (region)
    );

    mbus_ack_gen #(
        .ROM_WAIT  (ROM_WAIT),
        .UART_WAIT (UART_WAIT)
    ) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_n        (as_n),
        .region      (region),
        .dsack_n_out (dsack_n_out)
    );

    // Any agent, local or external, acknowledging this cycle
    assign ack_any = ((dsack_n_in & dsack_n_out) != ACK_IDLE);

    mbus_timeout #(
        .TIMEOUT (TIMEOUT)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n    (as_n),
        .ack_any (ack_any),
        .berr_n  (berr_n)
    );

    // Chip selects from the decoded window
    assign rom_cs_n  = (region != REG_ROM);
    assign uart_cs_n = (region != REG_UART);

endmodule

// File: rtl/mbus_ctrl_chk.sv
// Checker for mbus_ctrl: relates the selects, acknowledges and bus error
// to the strobe and to its own edge count since the strobe fell.
module mbus_ctrl_chk #(
    parameter int ADDR_W  = 32,
    parameter int TIMEOUT = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              as_n,
    input logic              rw,
    input logic [1:0]        dsack_n_in,
    input logic              rom_cs_n,
    input logic              uart_cs_n,
    input logic [1:0]        dsack_n_out,
    input logic              berr_n
);

    localparam int KW = $clog2(TIMEOUT + 2);
    localparam logic [KW-1:0] KMAX = KW'(TIMEOUT + 1);
    localparam logic [KW-1:0] KLIM = KW'(TIMEOUT);

    logic [KW-1:0] edges;
    logic          seen;

    // Independent count of strobed edges in the current cycle
    always_ff @(posedge clk) begin
        if (!rst_n || as_n)
            edges <= '0;
        else if (edges != KMAX)
            edges <= edges + 1'b1;
    end

    // Remembers an acknowledge seen before any bus error
    always_ff @(posedge clk) begin
        if (!rst_n || as_n)
            seen <= 1'b0;
        else if (((dsack_n_in & dsack_n_out) != 2'b11) && berr_n)
            seen <= 1'b1;
    end

    assert_rom_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> rom_cs_n);

    assert_lower_half_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !addr[ADDR_W-1]) |-> (rom_cs_n && uart_cs_n && dsack_n_out == 2'b11));

    assert_long_ack_only_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dsack_n_out == 2'b00) |-> !rom_cs_n);

    assert_byte_ack_only_uart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsack_n_out == 2'b10) |-> !uart_cs_n);

    assert_no_early_berr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_n |-> (edges >= KLIM));

    assert_ack_blocks_berr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> berr_n);

    assert_berr_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_n |=> (as_n || !berr_n));

    assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (rom_cs_n && uart_cs_n && berr_n && dsack_n_out == 2'b11));

    assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_cs_n && !uart_cs_n));

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dsack_n_out != 2'b01);

endmodule

bind mbus_ctrl mbus_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .TIMEOUT (TIMEOUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .as_n        (as_n),
    .rw          (rw),
    .dsack_n_in  (dsack_n_in),
    .rom_cs_n    (rom_cs_n),
    .uart_cs_n   (uart_cs_n),
    .dsack_n_out (dsack_n_out),
    .berr_n      (berr_n)
);

// File: tb/mbus_ctrl_tb.sv
`timescale 1ns/100ps
module mbus_ctrl_tb;

    localparam int ROM_WAIT  = 1;
    localparam int UART_WAIT = 3;
    localparam int TIMEOUT   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic [1:0]  ext_n = 2'b11;
    logic        rom_cs_n, uart_cs_n, berr_n;
    logic [1:0]  dsack_n_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbus_ctrl #(
        .ROM_WAIT  (ROM_WAIT),
        .UART_WAIT (UART_WAIT),
        .TIMEOUT   (TIMEOUT)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .as_n        (as_n),
        .rw          (rw),
        .dsack_n_in  (ext_n),
        .rom_cs_n    (rom_cs_n),
        .uart_cs_n   (uart_cs_n),
        .dsack_n_out (dsack_n_out),
        .berr_n      (berr_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One bus cycle held for `hold` samples; ext_at < 0 means no external ack
    task automatic run_cycle(input logic [31:0] a, input logic r,
                             input int ext_at, input int hold, input string req);
        int page, exp_sel, exp_code, exp_ack_idx, exp_berr_idx;
        int ack_idx, ack_code, berr_idx, berr_gap;
        page = int'(a[31:19]);
        exp_sel = 0;
        if (a[31] && page == 32'h1000 && r) exp_sel = 1;
        else if (a[31] && page == 32'h1001) exp_sel = 2;
        exp_code     = (exp_sel == 1) ? 0 : (exp_sel == 2) ? 2 : 3;
        exp_ack_idx  = (exp_sel == 1) ? ROM_WAIT : (exp_sel == 2) ? UART_WAIT : -1;
        exp_berr_idx = -1;
        if (exp_sel == 0 && (ext_at < 0 || ext_at >= TIMEOUT) && hold > TIMEOUT)
            exp_berr_idx = TIMEOUT;
        ack_idx = -1; ack_code = 3; berr_idx = -1; berr_gap = 0;
        @(negedge clk);
        addr = a; rw = r; as_n = 1'b0; ext_n = 2'b11;
        for (int i = 0; i < hold; i++) begin
            if (i == ext_at) ext_n = 2'b00;
            #1;
            if (i == 0)
                check({uart_cs_n, rom_cs_n} ==
                      ((exp_sel == 1) ? 2'b10 : (exp_sel == 2) ? 2'b01 : 2'b11),
                      req, "select pattern", int'({uart_cs_n, rom_cs_n}),
                      (exp_sel == 1) ? 2 : (exp_sel == 2) ? 1 : 3);
            if (ack_idx < 0 && dsack_n_out != 2'b11) begin
                ack_idx = i; ack_code = int'(dsack_n_out);
            end
            if (berr_idx < 0 && !berr_n) berr_idx = i;
            else if (berr_idx >= 0 && berr_n) berr_gap = 1;
            @(negedge clk);
        end
        check(ack_idx == exp_ack_idx, req, "local ack sample", ack_idx, exp_ack_idx);
        check(ack_code == exp_code, req, "local ack code", ack_code, exp_code);
        check(berr_idx == exp_berr_idx, req, "bus error sample", berr_idx, exp_berr_idx);
        if (berr_idx >= 0)
            check(berr_gap == 0, "R8", "bus error held while strobed", berr_gap, 0);
        as_n = 1'b1; ext_n = 2'b11;
        #1;
        check(berr_n && rom_cs_n && uart_cs_n && dsack_n_out == 2'b11, "R8 R10",
              "release on strobe high",
              int'({berr_n, rom_cs_n, uart_cs_n, dsack_n_out}), 31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(berr_n && rom_cs_n && uart_cs_n && dsack_n_out == 2'b11, "R10",
              "reset state", int'({berr_n, rom_cs_n, uart_cs_n, dsack_n_out}), 31);

        // Sweep of the eight lowest upper-half pages, both directions: R1 R2 R4 R5 R6
        for (int pg = 0; pg < 8; pg++) begin
            for (int d = 0; d < 2; d++) begin
                logic [31:0] a;
                a = 32'h8000_0000 + (32'(pg) << 19) + 32'(pg * 4);
                run_cycle(a, d[0], -1, TIMEOUT + 4,
                          (pg == 0) ? "R1 R4" : (pg == 1) ? "R2 R5" : "R6");
            end
        end

        // Lower half is left to the memory card: R3
        run_cycle(32'h0000_0000, 1'b1, 2, 6, "R3");
        run_cycle(32'h0008_0000, 1'b0, 5, 8, "R3");
        run_cycle(32'h7FFF_FFFC, 1'b1, -1, TIMEOUT + 4, "R3 R6");

        // External ack on unmapped upper space, around the limit: R7
        run_cycle(32'h8010_0000, 1'b1, 0, 4, "R7");
        run_cycle(32'hFFFF_FFFC, 1'b0, TIMEOUT - 1, TIMEOUT + 3, "R7");
        run_cycle(32'hC000_0000, 1'b1, TIMEOUT, TIMEOUT + 3, "R7");

        // Re-arm on strobe release: R9
        run_cycle(32'h9000_0000, 1'b1, -1, 40, "R9");
        run_cycle(32'h9000_0000, 1'b1, -1, TIMEOUT + 4, "R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule